// File: doc/BRIEF.md
# SCSI Initiator Selection Sequencer

This block carries out the initiator's part of a SCSI selection. A controller hands it one of four select variants, together with a target ID and a bit that says whether the target answered. The four variants are: no attention, attention with one message byte, attention-and-stop, and attention with three message bytes.

If the target answered, the sequencer takes the message bytes from the controller FIFO and checks the first of them as an identify message. It then streams the command bytes, either from the bytes left in the FIFO or, in DMA mode, from a DMA byte port for a programmed count. Every outgoing byte appears on a transmit strobe, with a flag that marks message bytes.

When the sequence ends, the block posts a one-cycle result. The result carries interrupt-bit set pulses, a step code, the next bus phase and the connection state, which a status register bank above it latches.

The block works on one selection at a time. A new command is taken only while it is idle. Bus arbitration and wire timing belong to the layer below.

Top module: `scsi_sel_seq`

## Requirements
- R1: After reset, conn_state is 0, step is 0, phase is 0, busy is low and no interrupt pulse is active.
- R2: The variant code on cmd_kind selects the number of message bytes popped from the FIFO, each marked by tx_msg=1. Code 0 (no attention) pops 0 bytes, codes 1 (attention) and 2 (attention-and-stop) pop 1 byte, and code 3 (attention, three bytes) pops 3 bytes.
- R3: In the cycle after a command is accepted, phase reads 2 (command), or 6 (message-out) for code 2, and sel_target holds the accepted target ID.
- R4: With tgt_present low at acceptance, the block pops nothing and posts irq_int and irq_dis, step 0 and conn_state 0 (disconnected). It pulses fifo_flush, so the FIFO ends empty, and phase stays at its accept value.
- R5: The first message byte is a valid identify only if it is exactly 0x80 or 0xC0 (LUN field bits 2:0 zero, bit 7 set, bits 5:3 zero). Otherwise the block pops the remaining message bytes and sends no command bytes. It then posts irq_int and irq_dis, step 0 and conn_state 0, with no flush and phase unchanged.
- R6: Code 2 with a valid identify ends after the message byte and sends no command bytes. It posts irq_int, irq_fc and irq_bs, step 1, phase 6 and conn_state 1 (initiator), and leaves the remaining FIFO bytes in place.
- R7: After the command bytes of a successful selection, the block posts irq_int, irq_fc and irq_bs, step 4 and conn_state 1. The next phase comes from tgt_resp: bit 1 set gives data-out (0), otherwise bit 0 set gives data-in (1), otherwise status (3).
- R8: Without DMA, every byte left in the FIFO after the message bytes is sent as a command byte (tx_msg=0), in FIFO order, until the FIFO is empty.
- R9: With cmd_dma set, exactly xfer_count command bytes are taken from dma_rdata, one per dma_take, with a count of 0 meaning 2^CNT_W. The FIFO is left untouched after the message bytes.
- R10: busy rises only on an accepted command and stays high through a one-cycle done pulse. A command offered while busy is ignored, and no byte moves while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_kind | input | 2 | Select variant code |
| cmd_dma | input | 1 | Command bytes come from the DMA port |
| cmd_target | input | ID_W | Target ID for this selection |
| tgt_present | input | 1 | Target answered selection (sampled at acceptance) |
| tgt_resp | input | 2 | Target response: bit 1 wants output, bit 0 has input |
| xfer_count | input | CNT_W | DMA command length, 0 means 2^CNT_W |
| fifo_empty | input | 1 | Controller FIFO is empty |
| fifo_rdata | input | DATA_W | FIFO head byte |
| fifo_pop | output | 1 | Consume the FIFO head at this edge |
| fifo_flush | output | 1 | Empty the FIFO |
| dma_rdata | input | DATA_W | Current DMA byte |
| dma_take | output | 1 | Consume the DMA byte at this edge |
| tx_valid | output | 1 | A byte is sent to the target this cycle |
| tx_msg | output | 1 | The sent byte is a message byte |
| tx_data | output | DATA_W | Sent byte |
| sel_target | output | ID_W | Target ID of the current or last selection |
| busy | output | 1 | A selection is in progress |
| done | output | 1 | One-cycle result strobe |
| irq_int | output | 1 | Set the status interrupt flag |
| irq_fc | output | 1 | Set the function-complete interrupt bit |
| irq_bs | output | 1 | Set the bus-service interrupt bit |
| irq_dis | output | 1 | Set the disconnect interrupt bit |
| step | output | 3 | Sequence step code |
| phase | output | 3 | Current bus phase code |
| conn_state | output | 2 | 0 disconnected, 1 initiator, 2 target |

## Verification
The assertions assume a well-behaved FIFO and DMA port. fifo_rdata must be valid whenever fifo_empty is low, and the FIFO changes only through the pop and flush outputs. A DMA byte must be available in every cycle, and tgt_resp must hold steady from acceptance until the result is posted. The bench meets these conditions with a queue-based FIFO model that it loads only while the sequencer is idle. It answers pops and flushes at the following falling edge, serves DMA bytes from a computed pattern, and changes tgt_present and tgt_resp only between commands. The one exception is the deliberately ignored intruding command.

// File: rtl/scsi_sel_pkg.sv
package scsi_sel_pkg;

   localparam int STEP_W = 3;

   typedef enum logic [1:0] {
      SEL_PLAIN    = 2'd0,
      SEL_ATN      = 2'd1,
      SEL_ATN_STOP = 2'd2,
      SEL_ATN3     = 2'd3
   } sel_kind_e;

   // phase codes are decoded by the status logic above this block
   typedef enum logic [2:0] {
      PH_DATA_OUT = 3'd0,
      PH_DATA_IN  = 3'd1,
      PH_COMMAND  = 3'd2,
      PH_STATUS   = 3'd3,
      PH_MSG_OUT  = 3'd6,
      PH_MSG_IN   = 3'd7
   } bus_phase_e;

   typedef enum logic [1:0] {
      LINK_NONE      = 2'd0,
      LINK_INITIATOR = 2'd1,
      LINK_TARGET    = 2'd2
   } link_e;

   typedef enum logic [1:0] {
      RES_ABSENT,
      RES_BAD_ID,
      RES_STOPPED,
      RES_SENT
   } result_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_MSG,
      SQ_CMD,
      SQ_POST
   } seq_state_e;

   function automatic logic [1:0] msg_bytes(sel_kind_e k);
      case (k)
         SEL_PLAIN: return 2'd0;
         SEL_ATN3:  return 2'd3;
         default:   return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/scsi_sel_idchk.sv
module scsi_sel_idchk #(
   parameter int DATA_W = 8,
   parameter int LUN_W  = 3
) (
   input  logic [DATA_W-1:0] msg_byte,
   output logic              ident_ok
);
   localparam int HI_W = DATA_W - LUN_W;

   if (HI_W < 3) begin : g_bad_width
      $error("scsi_sel_idchk: DATA_W too small for LUN_W");
   end

   logic [LUN_W-1:0] lun;
   logic [HI_W-1:0]  hi;

   assign lun = msg_byte[LUN_W-1:0];
   assign hi  = msg_byte[DATA_W-1:LUN_W];

   // top bit set, disconnect-permission bit free, reserved bits and LUN clear
   assign ident_ok = (lun == '0) && hi[HI_W-1] && (hi[HI_W-3:0] == '0);

endmodule

// File: rtl/scsi_sel_cmdsrc.sv
module scsi_sel_cmdsrc #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter bit DMA_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_count,
   input  logic              active,
   input  logic              use_dma,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_rdata,
   input  logic [DATA_W-1:0] dma_rdata,
   output logic              take_fifo,
   output logic              take_dma,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_byte,
   output logic              finished
);
   localparam int REM_W = CNT_W + 1;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("scsi_sel_cmdsrc: CNT_W must be at least 1");
   end

   if (DMA_EN) begin : g_dma
      logic [REM_W-1:0] remaining;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            remaining <= '0;
         else if (load)
            remaining <= (load_count == '0) ? (REM_W'(1) << CNT_W) : REM_W'(load_count);
         else if (take_dma)
            remaining <= remaining - 1'b1;
      end

      assign take_dma  = active && use_dma && (remaining != '0);
      assign take_fifo = active && !use_dma && !fifo_empty;
      assign finished  = active && (use_dma ? (remaining <= REM_W'(1)) : fifo_empty);

      AST_DMA_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
         take_dma && remaining > REM_W'(1) |=> take_dma); // R9
   end else begin : g_fifo_only
      assign take_dma  = 1'b0;
      assign take_fifo = active && !fifo_empty;
      assign finished  = active && fifo_empty;
   end

   assign out_valid = take_fifo | take_dma;
   assign out_byte  = take_dma ? dma_rdata : fifo_rdata;

endmodule

// File: rtl/scsi_sel_post.sv
module scsi_sel_post
   import scsi_sel_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  sel_kind_e         arm_kind,
   input  logic              commit,
   input  result_e           commit_res,
   input  logic [1:0]        resp,
   output logic [STEP_W-1:0] step,
   output bus_phase_e        phase,
   output link_e             link
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step  <= '0;
         phase <= PH_DATA_OUT;
         link  <= LINK_NONE;
      end else begin
         if (arm)
            phase <= (arm_kind == SEL_ATN_STOP) ? PH_MSG_OUT : PH_COMMAND;
         if (commit) begin
            case (commit_res)
               RES_STOPPED: begin
                  step  <= STEP_W'(1);
                  link  <= LINK_INITIATOR;
                  phase <= PH_MSG_OUT;
               end
               RES_SENT: begin
                  step  <= STEP_W'(4);
                  link  <= LINK_INITIATOR;
                  phase <= resp[1] ? PH_DATA_OUT : (resp[0] ? PH_DATA_IN : PH_STATUS);
               end
               default: begin
                  step <= '0;
                  link <= LINK_NONE;
               end
            endcase
         end
      end
   end

   AST_ARM_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      arm && !commit |=> (phase == PH_COMMAND || phase == PH_MSG_OUT)); // R3

endmodule

// File: rtl/scsi_sel_seq.sv
module scsi_sel_seq
   import scsi_sel_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter int ID_W   = 3,
   parameter bit DMA_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_kind,
   input  logic              cmd_dma,
   input  logic [ID_W-1:0]   cmd_target,
   input  logic              tgt_present,
   input  logic [1:0]        tgt_resp,
   input  logic [CNT_W-1:0]  xfer_count,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_rdata,
   output logic              fifo_pop,
   output logic              fifo_flush,
   input  logic [DATA_W-1:0] dma_rdata,
   output logic              dma_take,
   output logic              tx_valid,
   output logic              tx_msg,
   output logic [DATA_W-1:0] tx_data,
   output logic [ID_W-1:0]   sel_target,
   output logic              busy,
   output logic              done,
   output logic              irq_int,
   output logic              irq_fc,
   output logic              irq_bs,
   output logic              irq_dis,
   output logic [STEP_W-1:0] step,
   output logic [2:0]        phase,
   output logic [1:0]        conn_state
);
   if (ID_W < 1) begin : g_bad_id
      $error("scsi_sel_seq: ID_W must be at least 1");
   end

   seq_state_e        state, state_nx;
   result_e           res_q, res_nx;
   sel_kind_e         kind_q, kind_in;
   logic              dma_q;
   logic [1:0]        msg_left;
   logic              id_bad;
   logic [ID_W-1:0]   target_q;

   logic              accept, msg_pop, first_msg, ident_ok, bad_now, commit;
   logic              src_take_fifo, src_take_dma, src_valid, src_fin;
   logic [DATA_W-1:0] src_byte;
   bus_phase_e        phase_e;
   link_e             link_e_q;

   assign kind_in   = sel_kind_e'(cmd_kind);
   assign accept    = (state == SQ_IDLE) && cmd_valid;
   assign msg_pop   = (state == SQ_MSG) && !fifo_empty;
   assign first_msg = (msg_left == msg_bytes(kind_q));
   assign bad_now   = id_bad | (first_msg & ~ident_ok);

   scsi_sel_idchk #(.DATA_W(DATA_W)) u_idchk (
      .msg_byte (fifo_rdata),
      .ident_ok (ident_ok)
   );

   scsi_sel_cmdsrc #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DMA_EN(DMA_EN)) u_cmdsrc (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .load_count (xfer_count),
      .active     (state == SQ_CMD),
      .use_dma    (dma_q),
      .fifo_empty (fifo_empty),
      .fifo_rdata (fifo_rdata),
      .dma_rdata  (dma_rdata),
      .take_fifo  (src_take_fifo),
      .take_dma   (src_take_dma),
      .out_valid  (src_valid),
      .out_byte   (src_byte),
      .finished   (src_fin)
   );

   always_comb begin
      state_nx = state;
      res_nx   = res_q;
      case (state)
         SQ_IDLE: if (cmd_valid) begin
            if (!tgt_present) begin
               state_nx = SQ_POST;
               res_nx   = RES_ABSENT;
            end else if (msg_bytes(kind_in) != 2'd0) begin
               state_nx = SQ_MSG;
            end else begin
               state_nx = SQ_CMD;
            end
         end
         SQ_MSG: if (msg_pop && msg_left == 2'd1) begin
            if (bad_now) begin
               state_nx = SQ_POST;
               res_nx   = RES_BAD_ID;
            end else if (kind_q == SEL_ATN_STOP) begin
               state_nx = SQ_POST;
               res_nx   = RES_STOPPED;
            end else begin
               state_nx = SQ_CMD;
            end
         end
         SQ_CMD: if (src_fin) begin
            state_nx = SQ_POST;
            res_nx   = RES_SENT;
         end
         default: state_nx = SQ_IDLE;
      endcase
   end

   assign commit = (state_nx == SQ_POST) && (state != SQ_POST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         res_q    <= RES_ABSENT;
         kind_q   <= SEL_PLAIN;
         dma_q    <= 1'b0;
         msg_left <= '0;
         id_bad   <= 1'b0;
         target_q <= '0;
      end else begin
         state <= state_nx;
         res_q <= res_nx;
         if (accept) begin
            kind_q   <= kind_in;
            dma_q    <= cmd_dma & DMA_EN;
            msg_left <= msg_bytes(kind_in);
            id_bad   <= 1'b0;
            target_q <= cmd_target;
         end else if (msg_pop) begin
            msg_left <= msg_left - 2'd1;
            id_bad   <= bad_now;
         end
      end
   end

   scsi_sel_post u_post (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (accept),
      .arm_kind   (kind_in),
      .commit     (commit),
      .commit_res (res_nx),
      .resp       (tgt_resp),
      .step       (step),
      .phase      (phase_e),
      .link       (link_e_q)
   );

   assign phase      = phase_e;
   assign conn_state = link_e_q;
   assign sel_target = target_q;
   assign busy       = (state != SQ_IDLE);
   assign done       = (state == SQ_POST);
   assign irq_int    = done;
   assign irq_dis    = done && (res_q == RES_ABSENT || res_q == RES_BAD_ID);
   assign irq_fc     = done && (res_q == RES_STOPPED || res_q == RES_SENT);
   assign irq_bs     = irq_fc;
   assign fifo_flush = done && (res_q == RES_ABSENT);
   assign fifo_pop   = msg_pop | src_take_fifo;
   assign dma_take   = src_take_dma;
   assign tx_valid   = msg_pop | src_valid;
   assign tx_msg     = (state == SQ_MSG);
   assign tx_data    = (state == SQ_MSG) ? fifo_rdata : src_byte;

   AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty); // R8
   AST_POST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid)); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_valid && !dma_take); // R10
   AST_DIS_UNLINKS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_dis |-> conn_state == 2'd0 && step == '0); // R4
   AST_FC_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fc |-> conn_state == 2'd1 && step != '0); // R7
   AST_FLUSH_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |-> irq_dis && !fifo_pop); // R4
   AST_STOP_MSG_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      done && step == 3'd1 |-> phase == 3'd6); // R6

endmodule

// File: tb/scsi_sel_seq_tb.sv
module scsi_sel_seq_tb;
   localparam int DATA_W = 8;
   localparam int CNT_W  = 16;
   localparam int ID_W   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_kind = '0;
   logic cmd_dma = 1'b0;
   logic [ID_W-1:0] cmd_target = '0;
   logic tgt_present = 1'b1;
   logic [1:0] tgt_resp = '0;
   logic [CNT_W-1:0] xfer_count = '0;
   logic fifo_empty = 1'b1;
   logic [DATA_W-1:0] fifo_rdata = '0;
   logic [DATA_W-1:0] dma_rdata = '0;
   logic fifo_pop, fifo_flush, dma_take, tx_valid, tx_msg, busy, done;
   logic irq_int, irq_fc, irq_bs, irq_dis;
   logic [DATA_W-1:0] tx_data;
   logic [ID_W-1:0] sel_target;
   logic [2:0] step, phase;
   logic [1:0] conn_state;

   always #5 clk = ~clk;

   scsi_sel_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ID_W(ID_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
      .cmd_dma(cmd_dma), .cmd_target(cmd_target), .tgt_present(tgt_present),
      .tgt_resp(tgt_resp), .xfer_count(xfer_count), .fifo_empty(fifo_empty),
      .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
      .dma_rdata(dma_rdata), .dma_take(dma_take), .tx_valid(tx_valid),
      .tx_msg(tx_msg), .tx_data(tx_data), .sel_target(sel_target), .busy(busy),
      .done(done), .irq_int(irq_int), .irq_fc(irq_fc), .irq_bs(irq_bs),
      .irq_dis(irq_dis), .step(step), .phase(phase), .conn_state(conn_state)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] fq[$];
   int exp_q[$];
   string exp_tag[$];
   int dma_idx = 0;
   bit pend_pop = 0, pend_flush = 0, pend_dma = 0;

   function automatic logic [7:0] dma_pat(int i);
      return 8'((i * 13 + 7) & 255);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // external FIFO / DMA model and per-clock byte stream comparison
   always @(negedge clk) begin
      if (pend_flush) fq.delete();
      else if (pend_pop && fq.size() > 0) void'(fq.pop_front());
      if (pend_dma) dma_idx++;
      fifo_empty = (fq.size() == 0);
      fifo_rdata = (fq.size() > 0) ? fq[0] : 8'h00;
      dma_rdata  = dma_pat(dma_idx);
      #1;
      pend_pop   = fifo_pop;
      pend_flush = fifo_flush;
      pend_dma   = dma_take;
      if (rst_n && tx_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected byte", {23'd0, tx_msg, tx_data}, -1);
         end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            chk({tx_msg, tx_data} == e[8:0], t, "sent byte {msg,data}",
                {23'd0, tx_msg, tx_data}, e);
         end
      end
   end

   task automatic run_sel(int kind, bit dma, int cnt, bit present, int resp,
                          int tgt, bit intrude);
      int n, rem, exp_ph_acc, exp_ph, exp_step, exp_conn, guard, len;
      bit bad, fail;
      logic [7:0] b0;
      n = (kind == 0) ? 0 : ((kind == 3) ? 3 : 1);
      exp_ph_acc = (kind == 2) ? 6 : 2;
      bad = 0;
      if (present && n > 0) begin
         b0 = fq[0];
         bad = !(b0 == 8'h80 || b0 == 8'hC0);
      end
      if (!present) begin
         fail = 1; exp_step = 0; exp_conn = 0; exp_ph = exp_ph_acc; rem = 0;
      end else begin
         for (int i = 0; i < n; i++) begin
            exp_q.push_back(256 + fq[i]);
            exp_tag.push_back("R2");
         end
         if (bad) begin
            fail = 1; exp_step = 0; exp_conn = 0; exp_ph = exp_ph_acc;
            rem = fq.size() - n;
         end else if (kind == 2) begin
            fail = 0; exp_step = 1; exp_conn = 1; exp_ph = 6; rem = fq.size() - n;
         end else begin
            fail = 0; exp_step = 4; exp_conn = 1;
            exp_ph = (resp >= 2) ? 0 : ((resp == 1) ? 3'd1 : 3'd3);
            if (dma) begin
               len = (cnt == 0) ? (1 << CNT_W) : cnt;
               for (int i = 0; i < len; i++) begin
                  exp_q.push_back(dma_pat(dma_idx + i));
                  exp_tag.push_back("R9");
               end
               rem = fq.size() - n;
            end else begin
               for (int i = n; i < fq.size(); i++) begin
                  exp_q.push_back(fq[i]);
                  exp_tag.push_back("R8");
               end
               rem = 0;
            end
         end
      end
      cmd_kind = 2'(kind); cmd_dma = dma; xfer_count = CNT_W'(cnt);
      tgt_present = present; tgt_resp = 2'(resp); cmd_target = ID_W'(tgt);
      cmd_valid = 1'b1;
      @(negedge clk); #2;
      if (intrude) begin
         cmd_kind = 2'd0; tgt_present = 1'b0; cmd_target = ID_W'(tgt + 1);
      end else begin
         cmd_valid = 1'b0;
      end
      chk(phase == 3'(exp_ph_acc), "R3", "phase after accept", phase, exp_ph_acc);
      chk(sel_target == ID_W'(tgt), "R3", "sel_target", sel_target, tgt);
      chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
      if (intrude) begin
         @(negedge clk); #2;
         cmd_valid = 1'b0; tgt_present = 1'b1;
         chk(sel_target == ID_W'(tgt), "R10", "target kept while busy", sel_target, tgt);
      end
      guard = 0;
      while (!done && guard < 70000) begin
         @(negedge clk); #2;
         guard++;
      end
      chk(done == 1'b1, "R10", "done reached", done, 1);
      chk(irq_int == 1'b1, fail ? "R4" : "R7", "irq_int", irq_int, 1);
      chk(irq_dis == fail, bad ? "R5" : "R4", "irq_dis", irq_dis, fail);
      chk(irq_fc == !fail && irq_bs == !fail, (kind == 2) ? "R6" : "R7",
          "irq_fc/irq_bs", {irq_fc, irq_bs}, {!fail, !fail});
      chk(step == 3'(exp_step), bad ? "R5" : ((kind == 2) ? "R6" : "R7"), "step", step, exp_step);
      chk(conn_state == 2'(exp_conn), present ? "R6" : "R4", "conn_state", conn_state, exp_conn);
      chk(phase == 3'(exp_ph), bad ? "R5" : "R7", "phase at post", phase, exp_ph);
      chk(fifo_flush == !present, "R4", "fifo_flush", fifo_flush, !present);
      @(negedge clk); #2;
      chk(done == 1'b0 && busy == 1'b0, "R10", "back to idle {done,busy}", {done, busy}, 0);
      chk(fq.size() == rem, dma ? "R9" : "R8", "FIFO bytes left", fq.size(), rem);
      chk(exp_q.size() == 0, "R8", "expected bytes not sent", exp_q.size(), 0);
      exp_q.delete(); exp_tag.delete(); fq.delete();
      repeat (2) @(negedge clk);
      #2;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      chk(conn_state == 0 && step == 0 && phase == 0, "R1", "reset state {conn,step,phase}",
          {conn_state, step, phase}, 0);
      chk(!busy && !irq_int && !irq_fc && !irq_dis && !tx_valid, "R1", "reset idle", busy, 0);

      fq = '{8'h80, 8'h12, 8'h34};
      run_sel(1, 0, 0, 0, 0, 5, 0);                   // R4 absent target
      fq = '{8'h03, 8'h00, 8'h10, 8'h20};
      run_sel(0, 0, 0, 1, 0, 1, 0);                   // R2 R8 no message, status
      fq = '{8'h80, 8'h28, 8'h01, 8'h02};
      run_sel(1, 0, 0, 1, 1, 2, 0);                   // R5 valid, R7 data-in
      fq = '{8'hC0, 8'h0A, 8'h0B};
      run_sel(1, 0, 0, 1, 2, 3, 0);                   // R7 data-out
      fq = '{8'h81, 8'h55, 8'h66};
      run_sel(1, 0, 0, 1, 0, 4, 0);                   // R5 LUN set
      fq = '{8'h40, 8'h77};
      run_sel(1, 0, 0, 1, 0, 6, 0);                   // R5 top bit clear
      fq = '{8'hC0, 8'h11, 8'h22};
      run_sel(2, 0, 0, 1, 0, 7, 0);                   // R6 stop variant
      fq = '{8'h87, 8'h11};
      run_sel(2, 0, 0, 1, 0, 0, 0);                   // R5 R6 stop with bad identify
      fq = '{8'h80, 8'h01, 8'h03, 8'h12, 8'h00, 8'h00};
      run_sel(3, 0, 0, 1, 3, 1, 0);                   // R2 three bytes, R7 priority
      fq = '{8'h80, 8'hEE};
      run_sel(1, 1, 5, 1, 1, 2, 0);                   // R9 DMA count 5
      fq = '{8'h80};
      run_sel(1, 1, 1, 1, 0, 3, 0);                   // R9 DMA count 1
      fq.delete();
      run_sel(0, 0, 0, 1, 0, 4, 0);                   // R8 empty command
      fq = '{8'hC0, 8'h01, 8'h02, 8'hA0, 8'hA1, 8'hA2};
      run_sel(3, 0, 0, 1, 1, 5, 1);                   // R10 command while busy ignored
      fq = '{8'h99};
      run_sel(0, 1, 0, 1, 2, 6, 0);                   // R9 count 0 means 2^CNT_W

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog expired: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule